// File: doc/BRIEF.md
# LIN-Capable Asynchronous Serial Transmitter

This block serializes bytes onto a single asynchronous line and, on request, emits a LIN break field followed by a high delimiter. A one-entry holding buffer accepts a byte from a write strobe. When transmission is enabled and the serializer is free, the byte moves into the serializer and the buffer reports empty again, ready for the next byte. Bit timing comes from an external baud tick: every bit of a frame or break ends on a tick.

A frame is a low start bit, the data bits least significant first, and one to four high stop bits. The stop count is chosen by two independent control bits. A break is requested by a one-cycle pulse and is accepted only in master mode. Its low length and its delimiter length come from two 2-bit selectors. A break requested while a frame is on the line waits until that frame has finished. A pending break is sent before a byte that is waiting in the buffer.

The status output `bus_idle` is high only when the buffer is empty, nothing is being shifted and no break is waiting. The line driver is gated by an output-enable input.

Top module: `lin_uart_tx`

## Requirements
- R1: A frame is one low start bit, then the 8 data bits with bit 0 first, then the stop bits, all high. Each bit ends on a clock edge where `baud_tick` is high. `bus_idle` is low until the last bit's tick and high after it.
- R2: The stop-bit count is 1 + 2*`stop_ext` + `stop_base`. So {stop_ext,stop_base} = 00 gives 1 stop bit, 01 gives 2, 10 gives 3 and 11 gives 4.
- R3: A write sets the buffer non-empty. If `tx_enable` is high and the serializer is free, the byte moves to the serializer on the following clock and `buf_empty` returns to 1. While `tx_enable` is low, the byte stays in the buffer and the line stays high.
- R4: `bus_idle` is low from the clock edge that takes a write. `bus_idle` is 1 exactly when the buffer is empty, no frame or break is being shifted and no break is pending.
- R5: In master mode, a `brk_req` pulse drives `bus_idle` low from the next clock. It then produces 13 + `brk_len_sel` low bit times followed by 1 + `delim_sel` high bit times.
- R6: A `brk_req` pulse with `master_mode` low is ignored: `bus_idle` stays 1 and the line stays high.
- R7: A break requested during a frame starts only after the frame's last stop bit. A pending break is sent before a byte that is waiting in the buffer, and that byte follows right after the break.
- R8: With `out_enable` low, `sout` is held high and `sout_oe` is low. With `out_enable` high, `sout_oe` is high and `sout` carries the line.
- R9: After reset, `sout` is high, `buf_empty` is 1 and `bus_idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse that ends the current bit |
| tx_enable | input | 1 | Allows the serializer to start a frame or break |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to be written |
| stop_base | input | 1 | Low bit of the stop-count selector |
| stop_ext | input | 1 | High bit of the stop-count selector |
| master_mode | input | 1 | Break requests are accepted only when this is high |
| brk_req | input | 1 | One-cycle break request |
| brk_len_sel | input | 2 | Break low length selector (13 + value bit times) |
| delim_sel | input | 2 | Delimiter length selector (1 + value bit times) |
| out_enable | input | 1 | Enables the serial line driver |
| sout | output | 1 | Serial line, high when idle or not enabled |
| sout_oe | output | 1 | Output-enable for the line driver |
| buf_empty | output | 1 | Holding buffer is empty |
| bus_idle | output | 1 | No data buffered, nothing shifting, no break pending |

## Verification
A byte write and a break request can arrive in the same cycle. A break request can also arrive while a frame is being shifted. The bench provokes the first case by raising `wr_en` and `brk_req` on the same clock. It then collects one bit per baud tick and expects the full break and delimiter first, followed at once by the complete frame, with `buf_empty` low throughout the break. For the second case, it raises the break request a few bits into a frame and expects the remaining frame bits, then the break, with no extra bit time between them.

// File: rtl/lin_tx_pkg.sv
`timescale 1ns/1ps
package lin_tx_pkg;
   typedef enum logic [1:0] {
      MODE_IDLE  = 2'd0,
      MODE_FRAME = 2'd1,
      MODE_BREAK = 2'd2
   } tx_mode_e;
endpackage

// File: rtl/lin_tx_holdbuf.sv
`timescale 1ns/1ps
module lin_tx_holdbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic [DATA_W-1:0] data,
   output logic              full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '1;
         full <= 1'b0;
      end else begin
         if (wr_en) begin
            data <= wr_data;
            full <= 1'b1;
         end else if (take) begin
            full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lin_tx_brk_arm.sv
`timescale 1ns/1ps
module lin_tx_brk_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic master,
   input  logic take,
   output logic pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pend <= 1'b0;
      else if (req && master) pend <= 1'b1;
      else if (take)          pend <= 1'b0;
   end
endmodule

// File: rtl/lin_tx_serializer.sv
`timescale 1ns/1ps
module lin_tx_serializer
   import lin_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start_frame,
   input  logic              start_break,
   input  logic [DATA_W-1:0] frame_data,
   input  logic [CNT_W-1:0]  frame_len,
   input  logic [CNT_W-1:0]  brk_low,
   input  logic [CNT_W-1:0]  brk_total,
   output logic              line,
   output logic              busy
);
   localparam int SH_W = DATA_W + 1;

   tx_mode_e         mode_q;
   logic [SH_W-1:0]  shreg_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] total_q;
   logic [CNT_W-1:0] low_q;
   logic             last_bit;

   assign last_bit = (cnt_q == total_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_IDLE;
         shreg_q <= '1;
         cnt_q   <= '0;
         total_q <= '0;
         low_q   <= '0;
      end else if (start_break) begin
         mode_q  <= MODE_BREAK;
         cnt_q   <= '0;
         total_q <= brk_total;
         low_q   <= brk_low;
      end else if (start_frame) begin
         mode_q  <= MODE_FRAME;
         shreg_q <= {frame_data, 1'b0};
         cnt_q   <= '0;
         total_q <= frame_len;
      end else if (mode_q != MODE_IDLE && tick) begin
         if (last_bit) begin
            mode_q  <= MODE_IDLE;
            shreg_q <= '1;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (mode_q == MODE_FRAME) shreg_q <= {1'b1, shreg_q[SH_W-1:1]};
         end
      end
   end

   always_comb begin
      unique case (mode_q)
         MODE_FRAME: line = shreg_q[0];
         MODE_BREAK: line = (cnt_q >= low_q);
         default:    line = 1'b1;
      endcase
   end

   assign busy = (mode_q != MODE_IDLE);
endmodule

// File: rtl/lin_uart_tx.sv
`timescale 1ns/1ps
module lin_uart_tx #(
   parameter int DATA_W   = 8,
   parameter int BRK_BASE = 13,
   parameter int SEL_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_enable,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              stop_base,
   input  logic              stop_ext,
   input  logic              master_mode,
   input  logic              brk_req,
   input  logic [SEL_W-1:0]  brk_len_sel,
   input  logic [SEL_W-1:0]  delim_sel,
   input  logic              out_enable,
   output logic              sout,
   output logic              sout_oe,
   output logic              buf_empty,
   output logic              bus_idle
);
   localparam int STOP_MAX  = 4;
   localparam int SEL_MAX   = (1 << SEL_W) - 1;
   localparam int FRAME_MAX = 1 + DATA_W + STOP_MAX;
   localparam int BRK_MAX   = BRK_BASE + SEL_MAX + 1 + SEL_MAX;
   localparam int LEN_MAX   = (FRAME_MAX > BRK_MAX) ? FRAME_MAX : BRK_MAX;
   localparam int CNT_W     = $clog2(LEN_MAX + 1);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("lin_uart_tx: DATA_W must lie in 5..9");
      end
      if (BRK_BASE < 11) begin : g_bad_brk
         $error("lin_uart_tx: BRK_BASE must be at least 11");
      end
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("lin_uart_tx: SEL_W must lie in 1..3");
      end
   endgenerate

   logic [DATA_W-1:0] buf_data;
   logic              buf_full;
   logic              brk_pend;
   logic              ser_busy;
   logic              ser_line;
   logic              may_start;
   logic              take_brk;
   logic              take_byte;
   logic [CNT_W-1:0]  frame_len;
   logic [CNT_W-1:0]  brk_low;
   logic [CNT_W-1:0]  brk_total;

   assign may_start = tx_enable && !ser_busy;
   assign take_brk  = may_start && brk_pend;
   assign take_byte = may_start && !brk_pend && buf_full;

   assign frame_len = CNT_W'(1 + DATA_W + 1) + CNT_W'({stop_ext, stop_base});
   assign brk_low   = CNT_W'(BRK_BASE) + CNT_W'(brk_len_sel);
   assign brk_total = brk_low + CNT_W'(1) + CNT_W'(delim_sel);

   lin_tx_holdbuf #(.DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take_byte),
      .data    (buf_data),
      .full    (buf_full)
   );

   lin_tx_brk_arm u_brk (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (brk_req),
      .master (master_mode),
      .take   (take_brk),
      .pend   (brk_pend)
   );

   lin_tx_serializer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (baud_tick),
      .start_frame (take_byte),
      .start_break (take_brk),
      .frame_data  (buf_data),
      .frame_len   (frame_len),
      .brk_low     (brk_low),
      .brk_total   (brk_total),
      .line        (ser_line),
      .busy        (ser_busy)
   );

   assign sout      = out_enable ? ser_line : 1'b1;
   assign sout_oe   = out_enable;
   assign buf_empty = !buf_full;
   assign bus_idle  = !buf_full && !ser_busy && !brk_pend;
endmodule

// File: rtl/lin_uart_tx_chk.sv
`timescale 1ns/1ps
module lin_uart_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic brk_req,
   input logic master_mode,
   input logic out_enable,
   input logic sout,
   input logic sout_oe,
   input logic buf_empty,
   input logic bus_idle
);
   assert_gated_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_enable |-> (sout && !sout_oe));

   assert_idle_line_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_idle |-> sout);

   assert_write_clears_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !bus_idle);

   assert_full_not_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_empty |-> !bus_idle);

   assert_break_clears_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req && master_mode) |=> !bus_idle);

   assert_slave_break_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_idle && brk_req && !master_mode && !wr_en) |=> bus_idle);
endmodule

bind lin_uart_tx lin_uart_tx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .brk_req     (brk_req),
   .master_mode (master_mode),
   .out_enable  (out_enable),
   .sout        (sout),
   .sout_oe     (sout_oe),
   .buf_empty   (buf_empty),
   .bus_idle    (bus_idle)
);

// File: tb/tb_lin_uart_tx.sv
`timescale 1ns/1ps
module tb_lin_uart_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       tx_enable = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       stop_base = 1'b0;
   logic       stop_ext = 1'b0;
   logic       master_mode = 1'b1;
   logic       brk_req = 1'b0;
   logic [1:0] brk_len_sel = 2'd0;
   logic [1:0] delim_sel = 2'd0;
   logic       out_enable = 1'b1;
   logic       sout, sout_oe, buf_empty, bus_idle;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lin_uart_tx dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_enable(tx_enable),
      .wr_en(wr_en), .wr_data(wr_data), .stop_base(stop_base), .stop_ext(stop_ext),
      .master_mode(master_mode), .brk_req(brk_req), .brk_len_sel(brk_len_sel),
      .delim_sel(delim_sel), .out_enable(out_enable), .sout(sout), .sout_oe(sout_oe),
      .buf_empty(buf_empty), .bus_idle(bus_idle)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one bit per tick; starts and ends at a falling edge
   task automatic collect(input int n, output logic [63:0] bits, output logic idle_last);
      bits = '1;
      idle_last = 1'b1;
      for (int i = 0; i < n; i++) begin
         bits[i] = sout;
         if (i == n - 1) idle_last = bus_idle;
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   function automatic logic [63:0] frame_bits(input logic [7:0] d, input int stops);
      logic [63:0] e = '1;
      e[0] = 1'b0;
      for (int k = 0; k < 8; k++) e[k+1] = d[k];
      return e;
   endfunction

   function automatic logic [63:0] break_bits(input int low);
      logic [63:0] e = '1;
      for (int k = 0; k < low; k++) e[k] = 1'b0;
      return e;
   endfunction

   task automatic send_frame(input logic [7:0] d, input logic ext, input logic base);
      logic [63:0] got;
      logic        il;
      int          stops;
      stops = 1 + 2 * int'(ext) + int'(base);
      stop_ext = ext; stop_base = base;
      wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R4 bus_idle low after write", {63'd0, bus_idle}, 64'd0);
      @(negedge clk);
      chk("R3 buffer empties on load", {63'd0, buf_empty}, 64'd1);
      collect(9 + stops, got, il);
      chk("R1/R2 frame bits", got, frame_bits(d, stops));
      chk("R2 busy through last stop bit", {63'd0, il}, 64'd0);
      chk("R1 idle after frame", {62'd0, bus_idle, sout}, 64'd3);
   endtask

   task automatic send_break(input logic [1:0] bl, input logic [1:0] dl);
      logic [63:0] got;
      logic        il;
      int          low;
      low = 13 + int'(bl);
      brk_len_sel = bl; delim_sel = dl; master_mode = 1'b1;
      brk_req = 1'b1;
      @(negedge clk);
      brk_req = 1'b0;
      chk("R5 bus_idle low after break request", {63'd0, bus_idle}, 64'd0);
      @(negedge clk);
      collect(low + 1 + int'(dl), got, il);
      chk("R5 break bits", got, break_bits(low));
      chk("R5 busy through delimiter", {63'd0, il}, 64'd0);
      chk("R5 idle after delimiter", {62'd0, bus_idle, sout}, 64'd3);
   endtask

   initial begin
      logic [63:0] got;
      logic        il;
      logic [63:0] e;
      repeat (3) @(negedge clk);
      chk("R9 reset line/flags", {61'd0, sout, buf_empty, bus_idle}, 64'h7);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 after release", {61'd0, sout, buf_empty, bus_idle}, 64'h7);

      // R1 R2 sweep: all stop codes with several bytes
      for (int s = 0; s < 4; s++) begin
         for (int b = 0; b < 6; b++) begin
            logic [7:0] d;
            d = (b == 0) ? 8'h00 : (b == 1) ? 8'hFF : (b == 2) ? 8'hA5 :
                (b == 3) ? 8'h3C : (b == 4) ? (8'h01 << s) : 8'h96 ^ 8'(s);
            send_frame(d, s[1], s[0]);
         end
      end

      // R5 sweep over both selectors
      for (int bl = 0; bl < 4; bl++)
         for (int dl = 0; dl < 4; dl++)
            send_break(2'(bl), 2'(dl));

      // R6 break outside master mode
      master_mode = 1'b0;
      brk_req = 1'b1;
      @(negedge clk);
      brk_req = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk("R6 ignored break", {62'd0, bus_idle, sout}, 64'd3);
         baud_tick = 1'b1; @(negedge clk); baud_tick = 1'b0; @(negedge clk);
      end
      master_mode = 1'b1;

      // R7 break during frame, one stop bit
      stop_ext = 1'b0; stop_base = 1'b0; brk_len_sel = 2'd1; delim_sel = 2'd2;
      wr_data = 8'h5A; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0; @(negedge clk);
      collect(3, got, il);
      e = frame_bits(8'h5A, 1);
      chk("R7 frame head", got, e | ~64'h7);
      brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
      chk("R7 frame still on line", {63'd0, bus_idle}, 64'd0);
      collect(7 + 14 + 3, got, il);
      e = (e >> 3) & 64'h7F;
      e = e | (break_bits(14) << 7);
      chk("R7 break follows frame", got, e);
      chk("R7 idle at end", {62'd0, bus_idle, sout}, 64'd3);

      // R7 simultaneous write and break: break first
      brk_len_sel = 2'd0; delim_sel = 2'd0;
      wr_data = 8'hC3; wr_en = 1'b1; brk_req = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; brk_req = 1'b0;
      @(negedge clk);
      chk("R7 byte held during break", {63'd0, buf_empty}, 64'd0);
      collect(14 + 10, got, il);
      e = (break_bits(13) & 64'h3FFF) | (frame_bits(8'hC3, 1) << 14);
      chk("R7 break then frame", got, e);
      chk("R7 idle at end", {62'd0, bus_idle, sout}, 64'd3);

      // R3 transmission disabled holds the byte
      tx_enable = 1'b0;
      wr_data = 8'h81; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
      repeat (5) @(negedge clk);
      chk("R3 held while disabled", {62'd0, buf_empty, sout}, 64'd1);
      tx_enable = 1'b1;
      @(negedge clk);
      chk("R3 loaded once enabled", {63'd0, buf_empty}, 64'd1);
      collect(10, got, il);
      chk("R3 frame after enable", got, frame_bits(8'h81, 1));

      // R8 output disabled
      out_enable = 1'b0;
      wr_data = 8'h00; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0; @(negedge clk);
      chk("R8 oe low", {63'd0, sout_oe}, 64'd0);
      collect(10, got, il);
      chk("R8 line held high", got, 64'hFFFF_FFFF_FFFF_FFFF);
      out_enable = 1'b1;
      @(negedge clk);
      chk("R8 oe high", {62'd0, sout_oe, sout}, 64'd3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule